// File: doc/BRIEF.md
# Chip-Select Bus Cycle Timing Generator

This block turns single host requests into asynchronous, SRAM-style bus cycles on one chip-select window. A NAND flash can then be run as memory-mapped I/O. The host presents a read or write with two select bits and write data. The block drives chip enable, an output-enable strobe for reads and a byte-enable strobe for writes. It also drives the address-latch and command-latch lines and a data bus with an output enable. When the access ends, the block returns a one-cycle done pulse and, for reads, the captured data.

The block runs on a clock at twice the bus clock rate, so each of its cycles is one half bus clock. Every strobe edge is set in half-clock steps. All timing comes from two 32-bit configuration words, upper and lower, which are latched when a request is accepted. The wait-state count sets the access length, and writes may add extra wait states. Each strobe has its own start offset, counted from the access start, and its own end offset, counted back from the access end. After every access the chip select stays high for a minimum time, and reads may add idle dead cycles on top of that.

Commands, addresses and data are told apart only by the two select bits, which the host takes from address bits 23 and 22. Those bits drive the address-latch and command-latch lines directly. A write to a protected window, or any request while the chip select is disabled, causes no bus activity and is answered with done and an error flag.

Top module: `csb_timing_gen`

## Requirements
- R1: A read holds bus_ce_n low for exactly 2*(W+1) consecutive half clocks, where W is cfg_upper[13:8]. The pins go active on the half clock after the accepting edge. req_ready is low while bus_ce_n is low.
- R2: A write holds bus_ce_n low for exactly 2*(W+1+S) half clocks, where S is cfg_upper[6:4].
- R3: Half clocks within an access are numbered from 0, and L is the access length. On reads, bus_re_n is low exactly on half clocks h with OA <= h and h+ON < L, where OA is cfg_lower[31:28] and ON is cfg_lower[27:24]. On writes, bus_re_n stays high.
- R4: On writes, bus_we_n is low exactly on half clocks h with WA <= h and h+WN < L, where WA is cfg_lower[23:20] and WN is cfg_lower[19:16].
- R5: When cfg_lower[11] is 1, bus_we_n stays high during reads. When it is 0, reads also drive bus_we_n low over the R4 window.
- R6: cfg_lower[10:8] equal to 3'b101 selects a 16-bit port, and any other code selects an 8-bit port. On an 8-bit port, bits 15:8 of bus_dout and of rsp_rdata are 0.
- R7: During a write access, bus_doe is 1 and bus_dout carries the write data on every half clock that bus_ce_n is low. Whenever bus_ce_n is high, bus_doe is 0 and both strobes are high.
- R8: A read captures bus_din on the last half clock of its bus_re_n window, which is the half clock h with h+ON+1 = L. rsp_done pulses on the first half clock with bus_ce_n high after a completed access, and rsp_rdata holds the captured value during that pulse.
- R9: Let G be the larger of cfg_upper[15:14] and, after a read only, cfg_upper[3:0]. When the next request is already waiting, bus_ce_n stays high for exactly 2*G+1 half clocks between two accesses.
- R10: During an access, bus_ale equals req_sel[1] and bus_cle equals req_sel[0], and both stay constant. When bus_ce_n is high, both are 0.
- R11: When cfg_lower[4] is 1, a write produces no chip-select or strobe activity. rsp_done and rsp_err both pulse on the half clock after the accepting edge. Reads still run normally.
- R12: When cfg_lower[0] is 0, any request produces no bus activity and is answered with rsp_done and rsp_err one half clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate; one cycle is one half bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_upper | input | 32 | Upper configuration word (wait states, write wait, dead cycles, chip-select gap) |
| cfg_lower | input | 32 | Lower configuration word (strobe offsets, byte-control, port size, protect, enable) |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Address bits 23:22 of the request; bit 1 selects address latch, bit 0 command latch |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block is idle and accepts a request on this edge |
| rsp_done | output | 1 | One-cycle pulse when a request finishes |
| rsp_err | output | 1 | Pulses with rsp_done when a request was refused |
| rsp_rdata | output | 16 | Captured read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_re_n | output | 1 | Output-enable strobe, active low |
| bus_we_n | output | 1 | Byte-enable write strobe, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_cle | output | 1 | Command latch enable |
| bus_dout | output | 16 | Data driven toward the device |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 16 | Data returned by the device |

## Verification
Suppose the half-clock counter, the latched length or the gap counter goes wrong. The port effect is a chip enable held low one or more half clocks too long or too short, and it shows within the access itself. The same fault moves the done pulse off its expected cycle. If the latched configuration or direction is corrupted, a strobe edge lands off its programmed half clock in the very first access. If the capture point drifts, rsp_rdata shows the filler value the device model drives outside the output-enable window, and this appears on the done pulse of that read. If the gap logic misses a dead cycle, the next chip-enable fall arrives early and the measured high time shows it.

// File: rtl/csb_pkg.sv
package csb_pkg;

    // Field widths fixed by the configuration word layout
    localparam int WSC_W  = 6;
    localparam int WWS_W  = 3;
    localparam int EDC_W  = 4;
    localparam int CNC_W  = 2;
    localparam int EDGE_W = 4;
    localparam int DSZ_W  = 3;

    // Longest access in half clocks: 2*(2^WSC_W + 2^WWS_W)
    localparam int HALF_W = $clog2(2 * ((1 << WSC_W) + (1 << WWS_W)) + 1);

    // Upper word field positions
    localparam int UP_EDC_LSB = 0;
    localparam int UP_WWS_LSB = 4;
    localparam int UP_WSC_LSB = 8;
    localparam int UP_CNC_LSB = 14;

    // Lower word field positions
    localparam int LO_OEA_LSB = 28;
    localparam int LO_OEN_LSB = 24;
    localparam int LO_WEA_LSB = 20;
    localparam int LO_WEN_LSB = 16;
    localparam int LO_EBC_BIT = 11;
    localparam int LO_DSZ_LSB = 8;
    localparam int LO_WP_BIT  = 4;
    localparam int LO_EN_BIT  = 0;

    localparam logic [DSZ_W-1:0] DSZ_WIDE = 3'b101;

    typedef struct packed {
        logic [WSC_W-1:0]  wait_st;
        logic [WWS_W-1:0]  wr_wait;
        logic [EDC_W-1:0]  dead_rd;
        logic [CNC_W-1:0]  cs_gap;
        logic [EDGE_W-1:0] oe_on;
        logic [EDGE_W-1:0] oe_off;
        logic [EDGE_W-1:0] we_on;
        logic [EDGE_W-1:0] we_off;
        logic              we_wr_only;
        logic              wide;
        logic              wr_prot;
        logic              cs_en;
    } csb_cfg_t;

    typedef struct packed {
        logic ce_n;
        logic re_n;
        logic we_n;
        logic doe;
        logic ale;
        logic cle;
    } csb_pins_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_GAP  = 2'd2
    } csb_state_t;

    localparam csb_pins_t CSB_PINS_IDLE = '{ce_n: 1'b1, re_n: 1'b1, we_n: 1'b1,
                                            doe: 1'b0, ale: 1'b0, cle: 1'b0};

    // Access length in half clocks
    function automatic logic [HALF_W-1:0] csb_len(csb_cfg_t c, logic wr);
        logic [HALF_W-1:0] n;
        n = HALF_W'(c.wait_st) + HALF_W'(1) + (wr ? HALF_W'(c.wr_wait) : HALF_W'(0));
        return n << 1;
    endfunction

    // Idle half clocks owed after an access
    function automatic logic [HALF_W-1:0] csb_gap(csb_cfg_t c, logic wr);
        logic [EDC_W-1:0] m;
        m = wr ? '0 : c.dead_rd;
        if (EDC_W'(c.cs_gap) > m) m = EDC_W'(c.cs_gap);
        return HALF_W'(m) << 1;
    endfunction

endpackage

// File: rtl/csb_cfg_decode.sv
module csb_cfg_decode
    import csb_pkg::*;
(
    input  logic [31:0] cfg_upper,
    input  logic [31:0] cfg_lower,
    output csb_cfg_t    cfg
);

    always_comb begin
        cfg.wait_st    = cfg_upper[UP_WSC_LSB +: WSC_W];
        cfg.wr_wait    = cfg_upper[UP_WWS_LSB +: WWS_W];
        cfg.dead_rd    = cfg_upper[UP_EDC_LSB +: EDC_W];
        cfg.cs_gap     = cfg_upper[UP_CNC_LSB +: CNC_W];
        cfg.oe_on      = cfg_lower[LO_OEA_LSB +: EDGE_W];
        cfg.oe_off     = cfg_lower[LO_OEN_LSB +: EDGE_W];
        cfg.we_on      = cfg_lower[LO_WEA_LSB +: EDGE_W];
        cfg.we_off     = cfg_lower[LO_WEN_LSB +: EDGE_W];
        cfg.we_wr_only = cfg_lower[LO_EBC_BIT];
        cfg.wide       = (cfg_lower[LO_DSZ_LSB +: DSZ_W] == DSZ_WIDE);
        cfg.wr_prot    = cfg_lower[LO_WP_BIT];
        cfg.cs_en      = cfg_lower[LO_EN_BIT];
    end

    // Fields this block does not act on
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_upper[31:16], cfg_upper[7],
                               cfg_lower[15:12], cfg_lower[7:5], cfg_lower[3:1]};

endmodule

// File: rtl/csb_lane_mask.sv
module csb_lane_mask #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic              wide,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign dout[g*LANE_W +: LANE_W] = din[g*LANE_W +: LANE_W];
        end else begin : g_upper
            assign dout[g*LANE_W +: LANE_W] = wide ? din[g*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/csb_strobe_gen.sv
module csb_strobe_gen
    import csb_pkg::*;
(
    input  csb_cfg_t          cfg,
    input  logic              wr,
    input  logic [HALF_W-1:0] h,
    input  logic [HALF_W-1:0] len,
    input  logic [1:0]        sel,
    output csb_pins_t         pins
);

    logic [HALF_W:0] h_x;
    logic [HALF_W:0] len_x;
    logic            oe_win;
    logic            we_win;

    assign h_x   = {1'b0, h};
    assign len_x = {1'b0, len};

    // Window: start offset counted forward, end offset counted back from the end
    assign oe_win = (h >= HALF_W'(cfg.oe_on)) && ((h_x + (HALF_W+1)'(cfg.oe_off)) < len_x);
    assign we_win = (h >= HALF_W'(cfg.we_on)) && ((h_x + (HALF_W+1)'(cfg.we_off)) < len_x);

    always_comb begin
        pins.ce_n = 1'b0;
        pins.re_n = !(!wr && oe_win);
        pins.we_n = !((wr || !cfg.we_wr_only) && we_win);
        pins.doe  = wr;
        pins.ale  = sel[1];
        pins.cle  = sel[0];
    end

endmodule

// File: rtl/csb_sequencer.sv
module csb_sequencer
    import csb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  csb_cfg_t          cfg_in,
    input  logic [DATA_W-1:0] bus_din,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              vis_act,
    output csb_cfg_t          vis_cfg,
    output logic              vis_wr,
    output logic [HALF_W-1:0] vis_h,
    output logic [HALF_W-1:0] vis_len,
    output logic [1:0]        vis_sel,
    output logic [DATA_W-1:0] vis_wdata
);

    csb_state_t        st_q;
    logic [HALF_W-1:0] h_q;
    logic [HALF_W-1:0] len_q;
    logic [HALF_W-1:0] gap_q;
    csb_cfg_t          cfg_q;
    logic              wr_q;
    logic [1:0]        sel_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    logic              accept;
    logic              refuse;
    logic              start;
    logic              last;
    logic              grab;
    logic [HALF_W-1:0] gap_need;
    logic [DATA_W-1:0] din_m;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign refuse    = !cfg_in.cs_en || (req_write && cfg_in.wr_prot);
    assign start     = accept && !refuse;
    assign last      = (st_q == ST_ACC) && (h_q == len_q - HALF_W'(1));
    assign gap_need  = csb_gap(cfg_q, wr_q);

    // Capture on the final half clock of the output-enable window
    assign grab = (st_q == ST_ACC) && !wr_q &&
                  (((HALF_W+1)'(h_q) + (HALF_W+1)'(cfg_q.oe_off) + (HALF_W+1)'(1))
                   == (HALF_W+1)'(len_q));

    csb_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rd_mask (
        .din  (bus_din),
        .wide (cfg_q.wide),
        .dout (din_m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            h_q     <= '0;
            len_q   <= '0;
            gap_q   <= '0;
            cfg_q   <= '0;
            wr_q    <= 1'b0;
            sel_q   <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= last || (accept && refuse);
            err_q  <= accept && refuse;
            if (grab) rdata_q <= din_m;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q    <= ST_ACC;
                        h_q     <= '0;
                        len_q   <= csb_len(cfg_in, req_write);
                        cfg_q   <= cfg_in;
                        wr_q    <= req_write;
                        sel_q   <= req_sel;
                        wdata_q <= req_wdata;
                    end
                end
                ST_ACC: begin
                    if (last) begin
                        if (gap_need == '0) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q  <= ST_GAP;
                            gap_q <= gap_need;
                        end
                    end else begin
                        h_q <= h_q + HALF_W'(1);
                    end
                end
                ST_GAP: begin
                    gap_q <= gap_q - HALF_W'(1);
                    if (gap_q == HALF_W'(1)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Look-ahead view of the half clock that the pins will show next
    always_comb begin
        vis_act   = 1'b0;
        vis_cfg   = cfg_q;
        vis_wr    = wr_q;
        vis_h     = h_q + HALF_W'(1);
        vis_len   = len_q;
        vis_sel   = sel_q;
        vis_wdata = wdata_q;
        if (start) begin
            vis_act   = 1'b1;
            vis_cfg   = cfg_in;
            vis_wr    = req_write;
            vis_h     = '0;
            vis_len   = csb_len(cfg_in, req_write);
            vis_sel   = req_sel;
            vis_wdata = req_wdata;
        end else if (st_q == ST_ACC && !last) begin
            vis_act = 1'b1;
        end
    end

    assign rsp_done  = done_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/csb_timing_gen.sv
module csb_timing_gen
    import csb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cfg_upper,
    input  logic [31:0]       cfg_lower,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_ce_n,
    output logic              bus_re_n,
    output logic              bus_we_n,
    output logic              bus_ale,
    output logic              bus_cle,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);

    csb_cfg_t          cfg_in;
    logic              vis_act;
    csb_cfg_t          vis_cfg;
    logic              vis_wr;
    logic [HALF_W-1:0] vis_h;
    logic [HALF_W-1:0] vis_len;
    logic [1:0]        vis_sel;
    logic [DATA_W-1:0] vis_wdata;
    logic [DATA_W-1:0] wdata_m;
    csb_pins_t         pins_nxt;
    csb_pins_t         pins_q;
    logic [DATA_W-1:0] dout_q;

    csb_cfg_decode u_decode (
        .cfg_upper (cfg_upper),
        .cfg_lower (cfg_lower),
        .cfg       (cfg_in)
    );

    csb_sequencer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .req_wdata (req_wdata),
        .cfg_in    (cfg_in),
        .bus_din   (bus_din),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .vis_act   (vis_act),
        .vis_cfg   (vis_cfg),
        .vis_wr    (vis_wr),
        .vis_h     (vis_h),
        .vis_len   (vis_len),
        .vis_sel   (vis_sel),
        .vis_wdata (vis_wdata)
    );

    csb_strobe_gen u_strobe (
        .cfg  (vis_cfg),
        .wr   (vis_wr),
        .h    (vis_h),
        .len  (vis_len),
        .sel  (vis_sel),
        .pins (pins_nxt)
    );

    csb_lane_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_wr_mask (
        .din  (vis_wdata),
        .wide (vis_cfg.wide),
        .dout (wdata_m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= CSB_PINS_IDLE;
            dout_q <= '0;
        end else begin
            pins_q <= vis_act ? pins_nxt : CSB_PINS_IDLE;
            dout_q <= (vis_act && vis_wr) ? wdata_m : '0;
        end
    end

    assign bus_ce_n = pins_q.ce_n;
    assign bus_re_n = pins_q.re_n;
    assign bus_we_n = pins_q.we_n;
    assign bus_ale  = pins_q.ale;
    assign bus_cle  = pins_q.cle;
    assign bus_doe  = pins_q.doe;
    assign bus_dout = dout_q;

endmodule

// File: rtl/csb_timing_chk.sv
module csb_timing_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic rsp_err,
    input logic bus_ce_n,
    input logic bus_re_n,
    input logic bus_we_n,
    input logic bus_doe,
    input logic bus_ale,
    input logic bus_cle
);

    a_r1_busy_during_access: assert property (@(posedge clk) disable iff (rst)
        !bus_ce_n |-> !req_ready);

    a_r3_oe_inside_read: assert property (@(posedge clk) disable iff (rst)
        !bus_re_n |-> (!bus_ce_n && !bus_doe));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        bus_ce_n |-> (bus_re_n && bus_we_n && !bus_doe));

    a_r8_done_after_access: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> bus_ce_n);

    a_r9_ce_fall_needs_accept: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ce_n) |-> $past(req_valid && req_ready));

    a_r10_latch_lines_steady: assert property (@(posedge clk) disable iff (rst)
        (!bus_ce_n && !$past(bus_ce_n)) |-> ($stable(bus_ale) && $stable(bus_cle)));

    a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

endmodule

bind csb_timing_gen csb_timing_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .bus_ce_n  (bus_ce_n),
    .bus_re_n  (bus_re_n),
    .bus_we_n  (bus_we_n),
    .bus_doe   (bus_doe),
    .bus_ale   (bus_ale),
    .bus_cle   (bus_cle)
);

// File: tb/csb_timing_gen_bench.sv
module csb_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_upper = 32'h0;
    logic [31:0] cfg_lower = 32'h0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = 2'b00;
    logic [15:0] req_wdata = 16'h0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_ce_n, bus_re_n, bus_we_n, bus_ale, bus_cle, bus_doe;
    logic [15:0] bus_dout, bus_din;
    logic [15:0] dev_val = 16'h0;

    always #2 clk = ~clk;

    // Device model: valid data only while output enable is low
    assign bus_din = !bus_re_n ? dev_val : 16'h5A5A;

    csb_timing_gen u_csb_timing_gen (
        .clk(clk), .rst(rst), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
        .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_ce_n(bus_ce_n),
        .bus_re_n(bus_re_n), .bus_we_n(bus_we_n), .bus_ale(bus_ale),
        .bus_cle(bus_cle), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int end_cyc = 0;
    int hi_cnt = 0;
    int last_gap = 0;

    typedef struct {
        bit          err;
        bit          chk;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Chip-enable high-time meter
    always @(negedge clk) begin
        if (bus_ce_n) hi_cnt = hi_cnt + 1;
        else begin
            if (hi_cnt != 0) last_gap = hi_cnt;
            hi_cnt = 0;
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 done with nothing pending", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_err == e.err, {e.tag, " error flag"}, 32'(rsp_err), 32'(e.err));
                check(cyc == end_cyc + 1, "R8 done cycle", 32'(cyc), 32'(end_cyc + 1));
                check(bus_ce_n && !bus_ale && !bus_cle, "R10 idle at done",
                      {29'd0, bus_ce_n, bus_ale, bus_cle}, 32'h4);
                if (e.chk)
                    check(rsp_rdata == e.data, {e.tag, " read data"}, 32'(rsp_rdata), 32'(e.data));
            end
        end
    end

    task automatic access(input bit wr, input logic [1:0] sel, input logic [15:0] wd, input string tag);
        exp_t e;
        bit rej;
        bit wide;
        int len, oea, oen, wea, wen;
        bit ebc;
        bit b_ce, b_re, b_we, b_d, b_al;
        rej  = !cfg_lower[0] || (wr && cfg_lower[4]);
        wide = (cfg_lower[10:8] == 3'b101);
        len  = 2 * (int'(cfg_upper[13:8]) + 1 + (wr ? int'(cfg_upper[6:4]) : 0));
        oea  = int'(cfg_lower[31:28]);
        oen  = int'(cfg_lower[27:24]);
        wea  = int'(cfg_lower[23:20]);
        wen  = int'(cfg_lower[19:16]);
        ebc  = cfg_lower[11];
        e.err  = rej;
        e.chk  = !rej && !wr;
        e.data = wide ? dev_val : {8'h00, dev_val[7:0]};
        e.tag  = rej ? (!cfg_lower[0] ? "R12" : "R11") : (wr ? "R11" : "R6 R8");
        exp_q.push_back(e);
        @(negedge clk);
        req_write = wr;
        req_sel   = sel;
        req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (rej) begin
            end_cyc = cyc - 1;
            b_ce = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!bus_ce_n || !bus_we_n || !bus_re_n || bus_doe) b_ce = 1'b1;
            end
            check(!b_ce, rej && !cfg_lower[0] ? "R12 no bus activity" : "R11 no bus activity",
                  32'(b_ce), 32'd0);
            return;
        end
        b_ce = 0; b_re = 0; b_we = 0; b_d = 0; b_al = 0;
        for (int h = 0; h < len; h++) begin
            bit xre, xwe;
            logic [15:0] xd;
            @(negedge clk);
            xre = !(!wr && h >= oea && h + oen < len);
            xwe = !((wr || !ebc) && h >= wea && h + wen < len);
            xd  = wr ? (wide ? wd : {8'h00, wd[7:0]}) : 16'h0;
            if (bus_ce_n !== 1'b0) b_ce = 1;
            if (bus_re_n !== xre) b_re = 1;
            if (bus_we_n !== xwe) b_we = 1;
            if (bus_doe !== wr || bus_dout !== xd) b_d = 1;
            if (bus_ale !== sel[1] || bus_cle !== sel[0]) b_al = 1;
        end
        end_cyc = cyc;
        check(!b_ce, wr ? {tag, " R2 chip enable length"} : {tag, " R1 chip enable length"}, 32'(b_ce), 32'd0);
        check(!b_re, {tag, " R3 output enable window"}, 32'(b_re), 32'd0);
        check(!b_we, wr ? {tag, " R4 write strobe window"} : {tag, " R5 strobe on read"}, 32'(b_we), 32'd0);
        check(!b_d,  {tag, " R7 R6 write data drive"}, 32'(b_d), 32'd0);
        check(!b_al, {tag, " R10 latch lines"}, 32'(b_al), 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
        summary();
        $finish;
    end

    initial begin
        cfg_upper = 32'h0000_0501;
        cfg_lower = 32'h3124_0B01;
        dev_val   = 16'hA7C3;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(bus_ce_n && bus_re_n && bus_we_n && !bus_doe && !rsp_done && req_ready,
              "R7 reset state", {26'd0, bus_ce_n, bus_re_n, bus_we_n, bus_doe, rsp_done, req_ready},
              32'h39);

        // 8-bit port, typical timing
        access(1'b0, 2'b00, 16'h0, "T1");
        access(1'b1, 2'b01, 16'h1270, "T2");
        check(last_gap == 3, "R9 gap after read (dead 1)", 32'(last_gap), 32'd3);
        access(1'b1, 2'b10, 16'h0034, "T3");
        check(last_gap == 1, "R9 gap after write", 32'(last_gap), 32'd1);

        // 16-bit port
        cfg_lower = 32'h3124_0D01;
        dev_val   = 16'h9E61;
        access(1'b0, 2'b11, 16'h0, "T4");
        access(1'b1, 2'b00, 16'hBEEF, "T5");

        // Extra write wait states
        cfg_upper = 32'h0000_0521;
        access(1'b1, 2'b01, 16'h5AA5, "T6");
        access(1'b0, 2'b00, 16'h0, "T7");

        // Byte enables also on reads
        cfg_upper = 32'h0000_0501;
        cfg_lower = 32'h3124_0501;
        dev_val   = 16'h1357;
        access(1'b0, 2'b00, 16'h0, "T8");
        access(1'b1, 2'b10, 16'hC0DE, "T9");

        // Gap: chip-select gap 1, dead cycles 2
        cfg_upper = 32'h0000_4502;
        cfg_lower = 32'h3124_0D01;
        access(1'b0, 2'b00, 16'h0, "T10");
        access(1'b0, 2'b00, 16'h0, "T11");
        check(last_gap == 5, "R9 gap read to read", 32'(last_gap), 32'd5);
        access(1'b1, 2'b01, 16'h0102, "T12");
        access(1'b1, 2'b01, 16'h0304, "T13");
        check(last_gap == 3, "R9 gap write to write", 32'(last_gap), 32'd3);

        // No gap at all
        cfg_upper = 32'h0000_0500;
        access(1'b0, 2'b00, 16'h0, "T14");
        access(1'b0, 2'b00, 16'h0, "T15");
        check(last_gap == 1, "R9 minimal gap", 32'(last_gap), 32'd1);

        // Other strobe offsets
        cfg_upper = 32'h0000_0300;
        cfg_lower = 32'h1200_0D01;
        dev_val   = 16'h2468;
        access(1'b0, 2'b00, 16'h0, "T16");
        access(1'b1, 2'b11, 16'h7E7E, "T17");

        // Shortest access
        cfg_upper = 32'h0000_0000;
        cfg_lower = 32'h0000_0D01;
        dev_val   = 16'hF00D;
        access(1'b0, 2'b00, 16'h0, "T18");
        access(1'b1, 2'b10, 16'h4321, "T19");

        // Write protect
        cfg_upper = 32'h0000_0501;
        cfg_lower = 32'h3124_0D11;
        dev_val   = 16'h8421;
        access(1'b1, 2'b00, 16'hFFFF, "T20");
        access(1'b0, 2'b00, 16'h0, "T21");

        // Chip select disabled
        cfg_lower = 32'h3124_0D00;
        access(1'b0, 2'b00, 16'h0, "T22");
        access(1'b1, 2'b01, 16'h1111, "T23");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8 all requests answered", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule